// File: doc/BRIEF.md
# Store Queue with Writeback Pointer

This block holds the in-flight stores of one thread of an out-of-order core in a circular buffer. A store takes an entry at the tail when it is dispatched, in program order, and the block returns the index of that entry. When the store later executes, its address, byte size and data are written into that entry by index. The retire logic sends a commit sequence number. Every held store older than that number becomes committed and eligible for writeback.

A writeback pointer, separate from the head and the tail, walks the buffer in order. It offers the oldest committed store that has not yet been sent to the data cache, and only while the cache is not blocked. Each offered store counts as sent in that cycle. The cache reports completion by entry index, in any order. An entry leaves the buffer only when it is at the head and its writeback is complete, so a committed store stays in the buffer until memory has it. A squash pulls the tail back over every store younger than a given sequence number.

The buffer has one spare physical slot, so its usable capacity is one less than the number of physical entries. The block reports the number of held stores, whether the buffer is full, how many stores are committed but not yet complete, and the sequence number of the oldest held store.

Top module: `store_wb_queue`

## Requirements
- R1: When `alloc_valid` is high, the buffer is not full and no squash is present, a store takes the slot at `tail_idx`. `tail_idx` then advances by one and wraps from ENTRIES-1 to 0. A request while full or during a squash leaves the buffer unchanged.
- R2: `count` gives the number of held stores. `full` is high exactly when `count` equals ENTRIES-1, so one physical slot always stays empty.
- R3: `exec_valid` writes `exec_addr`, `exec_size` and `exec_data` into the entry at `exec_idx`. These values are later offered unchanged on the writeback outputs. Execution changes neither `count` nor any commit or completion state.
- R4: With `commit_valid` and no squash in the same cycle, every held, not yet committed store whose sequence number is strictly less than `commit_seq` becomes committed. `wb_pending` rises by the number of stores newly committed.
- R5: `wb_valid` is high exactly when the entry at the writeback pointer is held, committed and not yet sent, and `cache_blocked` is low. The outputs then show that entry's index, address, size and data. Each cycle with `wb_valid` high sends that store, and the pointer moves to the next entry.
- R6: `wb_done` with `wb_done_idx` marks that entry's writeback as complete, and `wb_pending` falls by one.
- R7: The oldest held store leaves the buffer, and `count` falls, one clock after its completion is recorded. No entry is freed at commit, and younger completed entries wait behind an incomplete head.
- R8: `squash_valid` discards every held store whose sequence number is greater than `squash_seq`. `tail_idx` moves back to directly follow the youngest store kept. An allocation or commit request in the same cycle is ignored.
- R9: `head_seq` shows the sequence number of the oldest held store, and 0 when the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Request to take the tail slot for a new store |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| tail_idx | output | PTR_W | Slot the next allocation takes |
| exec_valid | input | 1 | Execution result is present |
| exec_idx | input | PTR_W | Slot of the executed store |
| exec_addr | input | ADDR_W | Effective address |
| exec_size | input | SIZE_W | Access size in bytes |
| exec_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Stores older than this become committed |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are discarded |
| cache_blocked | input | 1 | Data cache cannot accept a write this cycle |
| wb_valid | output | 1 | A store is sent to the cache this cycle |
| wb_idx | output | PTR_W | Slot of the store sent |
| wb_addr | output | ADDR_W | Address of the store sent |
| wb_size | output | SIZE_W | Size of the store sent |
| wb_data | output | DATA_W | Data of the store sent |
| wb_done | input | 1 | Cache reports a write complete |
| wb_done_idx | input | PTR_W | Slot whose write completed |
| count | output | CNT_W | Number of held stores |
| full | output | 1 | Buffer at usable capacity |
| wb_pending | output | CNT_W | Committed stores not yet complete |
| head_seq | output | SEQ_W | Sequence number of the oldest store, 0 if empty |

## Verification
The stimulus cycles through four traffic mixes. A mix heavy in allocation with rare commits pushes the buffer to full and exercises refused requests and tail wraparound. A draining mix, heavy in commits and completions, empties it. A mixed phase adds squashes to a random cut point at or beyond the committed prefix, sometimes together with allocation or commit requests, which must then be ignored. A phase with the cache mostly blocked shows whether the writeback offer is held back and whether out-of-order completions keep younger entries waiting behind an incomplete head.

// File: rtl/sq_pkg.sv
// Shared types and ring-index helpers for the store queue.
// Assumes ring sizes fit in 32 bits and any step added is at most the size.
package sq_pkg;

    // Per-entry state bits kept next to each store.
    typedef struct packed {
        logic valid;
        logic can_wb;
        logic committed;
        logic completed;
    } sq_flags_t;

    // Next slot index, wrapping at the physical entry count.
    function automatic int unsigned ring_step(int unsigned p, int unsigned n);
        return (p + 1 >= n) ? 0 : p + 1;
    endfunction

    // Slot index a given distance ahead, wrapping at the physical entry count.
    function automatic int unsigned ring_add(int unsigned p, int unsigned d, int unsigned n);
        int unsigned s;
        s = p + d;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/sq_entry_array.sv
// Storage for the store entries: sequence number, payload and state flags.
// Each slot compares its own sequence number against the commit and squash
// values. It assumes a slot is never allocated while it is still held.
module sq_entry_array
    import sq_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PTR_W   = 3,
    parameter int SEQ_W   = 16,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int SIZE_W  = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               alloc_en,
    input  logic [PTR_W-1:0]                   alloc_idx,
    input  logic [SEQ_W-1:0]                   alloc_seq,
    input  logic                               exec_en,
    input  logic [PTR_W-1:0]                   exec_idx,
    input  logic [ADDR_W-1:0]                  exec_addr,
    input  logic [SIZE_W-1:0]                  exec_size,
    input  logic [DATA_W-1:0]                  exec_data,
    input  logic                               commit_en,
    input  logic [SEQ_W-1:0]                   commit_seq,
    input  logic                               done_en,
    input  logic [PTR_W-1:0]                   done_idx,
    input  logic                               free_en,
    input  logic [PTR_W-1:0]                   free_idx,
    input  logic                               squash_en,
    input  logic [SEQ_W-1:0]                   squash_seq,
    output sq_flags_t [ENTRIES-1:0]            flags_o,
    output logic [ENTRIES-1:0][SEQ_W-1:0]      seq_o,
    output logic [ENTRIES-1:0][ADDR_W-1:0]     addr_o,
    output logic [ENTRIES-1:0][SIZE_W-1:0]     size_o,
    output logic [ENTRIES-1:0][DATA_W-1:0]     data_o,
    output logic [ENTRIES-1:0]                 commit_hit_o,
    output logic [ENTRIES-1:0]                 keep_hit_o
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        sq_flags_t          fl_q;
        logic [SEQ_W-1:0]   seq_q;
        logic [ADDR_W-1:0]  addr_q;
        logic [SIZE_W-1:0]  size_q;
        logic [DATA_W-1:0]  data_q;
        logic               here_alloc;
        logic               here_exec;
        logic               here_done;
        logic               here_free;
        logic               here_cut;

        assign here_alloc = alloc_en && (alloc_idx == PTR_W'(i));
        assign here_exec  = exec_en  && (exec_idx  == PTR_W'(i));
        assign here_done  = done_en  && (done_idx  == PTR_W'(i));
        assign here_free  = free_en  && (free_idx  == PTR_W'(i));

        // Newly committed: held, not yet committed, and older than the commit value.
        assign commit_hit_o[i] = commit_en && fl_q.valid && !fl_q.committed && (seq_q < commit_seq);
        // Survives a squash: held and not younger than the squash value.
        assign keep_hit_o[i]   = fl_q.valid && (seq_q <= squash_seq);
        assign here_cut        = squash_en && fl_q.valid && !keep_hit_o[i];

        // State flags: set on allocation, commit and completion; cleared on free or squash.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fl_q <= '0;
            end else if (here_alloc) begin
                fl_q.valid     <= 1'b1;
                fl_q.can_wb    <= 1'b0;
                fl_q.committed <= 1'b0;
                fl_q.completed <= 1'b0;
            end else begin
                if (commit_hit_o[i]) begin
                    fl_q.committed <= 1'b1;
                    fl_q.can_wb    <= 1'b1;
                end
                if (here_done) begin
                    fl_q.completed <= 1'b1;
                end
                if (here_free || here_cut) begin
                    fl_q.valid <= 1'b0;
                end
            end
        end

        // Payload: sequence number taken at allocation, address/size/data at execution.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seq_q  <= '0;
                addr_q <= '0;
                size_q <= '0;
                data_q <= '0;
            end else if (here_alloc) begin
                seq_q  <= alloc_seq;
                addr_q <= '0;
                size_q <= '0;
                data_q <= '0;
            end else if (here_exec) begin
                addr_q <= exec_addr;
                size_q <= exec_size;
                data_q <= exec_data;
            end
        end

        assign flags_o[i] = fl_q;
        assign seq_o[i]   = seq_q;
        assign addr_o[i]  = addr_q;
        assign size_o[i]  = size_q;
        assign data_o[i]  = data_q;
    end

endmodule

// File: rtl/sq_wb_select.sv
// Picks the entry at the writeback pointer and decides whether it goes to the
// cache this cycle. The choice is purely combinational.
// Assumes the pointer always lies below the physical entry count.
module sq_wb_select
    import sq_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PTR_W   = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int SIZE_W  = 4
) (
    input  logic [PTR_W-1:0]                   wb_ptr,
    input  sq_flags_t [ENTRIES-1:0]            flags_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]     addr_i,
    input  logic [ENTRIES-1:0][SIZE_W-1:0]     size_i,
    input  logic [ENTRIES-1:0][DATA_W-1:0]     data_i,
    input  logic                               cache_blocked,
    output logic                               wb_valid,
    output logic [ADDR_W-1:0]                  wb_addr,
    output logic [SIZE_W-1:0]                  wb_size,
    output logic [DATA_W-1:0]                  wb_data
);

    sq_flags_t sel;
    logic      ready;

    // Offer the pointed entry when it is committed and not yet complete.
    always_comb begin
        sel      = flags_i[wb_ptr];
        ready    = sel.valid && sel.can_wb && sel.committed && !sel.completed;
        wb_valid = ready && !cache_blocked;
        wb_addr  = addr_i[wb_ptr];
        wb_size  = size_i[wb_ptr];
        wb_data  = data_i[wb_ptr];
    end

endmodule

// File: rtl/sq_ring_ctrl.sv
// Head, writeback and tail pointers plus the occupancy and pending counters.
// Assumes a squash never discards a committed entry, so the writeback pointer
// is left as it is on a squash.
module sq_ring_ctrl
    import sq_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PTR_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic              squash_en,
    input  logic [CNT_W-1:0]  squash_keep,
    input  logic              head_completed,
    input  logic              wb_issue,
    input  logic [CNT_W-1:0]  commit_gain,
    input  logic              done_en,
    output logic [PTR_W-1:0]  head_o,
    output logic [PTR_W-1:0]  wb_ptr_o,
    output logic [PTR_W-1:0]  tail_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  pending_o,
    output logic              full_o,
    output logic              alloc_fire_o,
    output logic              free_fire_o
);

    localparam int CAP = ENTRIES - 1;

    logic [PTR_W-1:0] head_q, wbp_q, tail_q;
    logic [CNT_W-1:0] count_q, pend_q;

    assign full_o       = (count_q == CNT_W'(CAP));
    assign alloc_fire_o = alloc_req && !full_o && !squash_en;
    assign free_fire_o  = head_completed;

    // Pointer and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            wbp_q   <= '0;
            tail_q  <= '0;
            count_q <= '0;
            pend_q  <= '0;
        end else begin
            if (free_fire_o) begin
                head_q <= PTR_W'(ring_step(32'(head_q), ENTRIES));
            end
            if (wb_issue) begin
                wbp_q <= PTR_W'(ring_step(32'(wbp_q), ENTRIES));
            end
            if (squash_en) begin
                tail_q  <= PTR_W'(ring_add(32'(head_q), 32'(squash_keep), ENTRIES));
                count_q <= squash_keep - CNT_W'(free_fire_o);
            end else begin
                if (alloc_fire_o) begin
                    tail_q <= PTR_W'(ring_step(32'(tail_q), ENTRIES));
                end
                count_q <= count_q + CNT_W'(alloc_fire_o) - CNT_W'(free_fire_o);
            end
            pend_q <= pend_q + commit_gain - CNT_W'(done_en);
        end
    end

    assign head_o    = head_q;
    assign wb_ptr_o  = wbp_q;
    assign tail_o    = tail_q;
    assign count_o   = count_q;
    assign pending_o = pend_q;

endmodule

// File: rtl/store_wb_queue.sv
// Top of the store queue. It connects the entry storage, the pointer/counter
// controller and the writeback selector. Sequence numbers are assumed to rise
// monotonically without wrapping, and completions are assumed only for slots
// that have been sent to the cache.
module store_wb_queue
    import sq_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int SEQ_W   = 16,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int SIZE_W  = 4,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    output logic [PTR_W-1:0]  tail_idx,
    input  logic              exec_valid,
    input  logic [PTR_W-1:0]  exec_idx,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [SIZE_W-1:0] exec_size,
    input  logic [DATA_W-1:0] exec_data,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              cache_blocked,
    output logic              wb_valid,
    output logic [PTR_W-1:0]  wb_idx,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [SIZE_W-1:0] wb_size,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_done,
    input  logic [PTR_W-1:0]  wb_done_idx,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic [CNT_W-1:0]  wb_pending,
    output logic [SEQ_W-1:0]  head_seq
);

    sq_flags_t [ENTRIES-1:0]           flags;
    logic [ENTRIES-1:0][SEQ_W-1:0]     seqs;
    logic [ENTRIES-1:0][ADDR_W-1:0]    addrs;
    logic [ENTRIES-1:0][SIZE_W-1:0]    sizes;
    logic [ENTRIES-1:0][DATA_W-1:0]    datas;
    logic [ENTRIES-1:0]                commit_hit;
    logic [ENTRIES-1:0]                keep_hit;
    logic [PTR_W-1:0]                  head_ptr, wb_ptr, tail_ptr;
    logic                              alloc_fire, free_fire, commit_en;
    logic [CNT_W-1:0]                  commit_gain, squash_keep;
    sq_flags_t                         head_fl;

    // A squash takes priority over a commit request in the same cycle.
    assign commit_en   = commit_valid && !squash_valid;
    assign commit_gain = CNT_W'($countones(commit_hit));
    assign squash_keep = CNT_W'($countones(keep_hit));
    assign head_fl     = flags[head_ptr];

    sq_entry_array #(
        .ENTRIES (ENTRIES), .PTR_W (PTR_W), .SEQ_W (SEQ_W),
        .ADDR_W  (ADDR_W),  .DATA_W (DATA_W), .SIZE_W (SIZE_W)
    ) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_en     (alloc_fire),
        .alloc_idx    (tail_ptr),
        .alloc_seq    (alloc_seq),
        .exec_en      (exec_valid),
        .exec_idx     (exec_idx),
        .exec_addr    (exec_addr),
        .exec_size    (exec_size),
        .exec_data    (exec_data),
        .commit_en    (commit_en),
        .commit_seq   (commit_seq),
        .done_en      (wb_done),
        .done_idx     (wb_done_idx),
        .free_en      (free_fire),
        .free_idx     (head_ptr),
        .squash_en    (squash_valid),
        .squash_seq   (squash_seq),
        .flags_o      (flags),
        .seq_o        (seqs),
        .addr_o       (addrs),
        .size_o       (sizes),
        .data_o       (datas),
        .commit_hit_o (commit_hit),
        .keep_hit_o   (keep_hit)
    );

    sq_ring_ctrl #(
        .ENTRIES (ENTRIES), .PTR_W (PTR_W), .CNT_W (CNT_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_req      (alloc_valid),
        .squash_en      (squash_valid),
        .squash_keep    (squash_keep),
        .head_completed (head_fl.valid && head_fl.completed),
        .wb_issue       (wb_valid),
        .commit_gain    (commit_gain),
        .done_en        (wb_done),
        .head_o         (head_ptr),
        .wb_ptr_o       (wb_ptr),
        .tail_o         (tail_ptr),
        .count_o        (count),
        .pending_o      (wb_pending),
        .full_o         (full),
        .alloc_fire_o   (alloc_fire),
        .free_fire_o    (free_fire)
    );

    sq_wb_select #(
        .ENTRIES (ENTRIES), .PTR_W (PTR_W), .ADDR_W (ADDR_W),
        .DATA_W  (DATA_W),  .SIZE_W (SIZE_W)
    ) u_wbsel (
        .wb_ptr        (wb_ptr),
        .flags_i       (flags),
        .addr_i        (addrs),
        .size_i        (sizes),
        .data_i        (datas),
        .cache_blocked (cache_blocked),
        .wb_valid      (wb_valid),
        .wb_addr       (wb_addr),
        .wb_size       (wb_size),
        .wb_data       (wb_data)
    );

    assign tail_idx = tail_ptr;
    assign wb_idx   = wb_ptr;
    assign head_seq = head_fl.valid ? seqs[head_ptr] : '0;

endmodule

// File: rtl/sq_checker.sv
// Protocol properties of the store queue, observed at its ports.
// The checker is attached to every instance of the top through bind.
module sq_checker #(
    parameter int ENTRIES = 8,
    parameter int SEQ_W   = 16,
    parameter int PTR_W   = 3,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             squash_valid,
    input logic             cache_blocked,
    input logic             full,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] wb_pending,
    input logic             wb_valid,
    input logic [PTR_W-1:0] wb_idx,
    input logic [SEQ_W-1:0] head_seq
);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(ENTRIES - 1));

    assert_full_refuses_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_valid) |=> (count <= $past(count)));

    assert_blocked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cache_blocked |-> !wb_valid);

    assert_ptr_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (!wb_valid || (wb_idx != $past(wb_idx))));

    assert_pending_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_pending <= count);

    assert_squash_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> (count <= $past(count)));

    assert_empty_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (head_seq == '0));

endmodule

bind store_wb_queue sq_checker #(
    .ENTRIES (ENTRIES), .SEQ_W (SEQ_W), .PTR_W (PTR_W), .CNT_W (CNT_W)
) u_sq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid   (alloc_valid),
    .squash_valid  (squash_valid),
    .cache_blocked (cache_blocked),
    .full          (full),
    .count         (count),
    .wb_pending    (wb_pending),
    .wb_valid      (wb_valid),
    .wb_idx        (wb_idx),
    .head_seq      (head_seq)
);

// File: tb/store_wb_queue_bench.sv
`timescale 1ns/1ps
module store_wb_queue_bench;

    localparam int E  = 8;
    localparam int SW = 16;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int ZW = 4;
    localparam int PW = $clog2(E);
    localparam int CW = $clog2(E + 1);
    localparam int CYCLES = 4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [SW-1:0] alloc_seq = '0;
    logic [PW-1:0] tail_idx;
    logic          exec_valid = 1'b0;
    logic [PW-1:0] exec_idx = '0;
    logic [AW-1:0] exec_addr = '0;
    logic [ZW-1:0] exec_size = '0;
    logic [DW-1:0] exec_data = '0;
    logic          commit_valid = 1'b0;
    logic [SW-1:0] commit_seq = '0;
    logic          squash_valid = 1'b0;
    logic [SW-1:0] squash_seq = '0;
    logic          cache_blocked = 1'b0;
    logic          wb_valid;
    logic [PW-1:0] wb_idx;
    logic [AW-1:0] wb_addr;
    logic [ZW-1:0] wb_size;
    logic [DW-1:0] wb_data;
    logic          wb_done = 1'b0;
    logic [PW-1:0] wb_done_idx = '0;
    logic [CW-1:0] count;
    logic          full;
    logic [CW-1:0] wb_pending;
    logic [SW-1:0] head_seq;

    always #2 clk = ~clk;

    store_wb_queue #(.ENTRIES(E), .SEQ_W(SW), .ADDR_W(AW), .DATA_W(DW), .SIZE_W(ZW)) u_store_wb_queue (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
        .tail_idx(tail_idx), .exec_valid(exec_valid), .exec_idx(exec_idx),
        .exec_addr(exec_addr), .exec_size(exec_size), .exec_data(exec_data),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .cache_blocked(cache_blocked), .wb_valid(wb_valid), .wb_idx(wb_idx),
        .wb_addr(wb_addr), .wb_size(wb_size), .wb_data(wb_data),
        .wb_done(wb_done), .wb_done_idx(wb_done_idx), .count(count), .full(full),
        .wb_pending(wb_pending), .head_seq(head_seq)
    );

    // Reference entry, oldest first in the queue below.
    typedef struct {
        int          seq;
        int          idx;
        logic [31:0] addr;
        logic [31:0] data;
        int          size;
        bit          execd;
        bit          comm;
        bit          iss;
        bit          comp;
    } ment_t;

    ment_t q[$];
    int    sent[$];
    int    head_i = 0;
    int    tail_i = 0;
    int    next_seq = 1;
    int    total = 0;
    int    bad = 0;
    bit    reported = 0;

    task automatic check(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    // Draw this cycle's inputs from the reference state and the traffic mix.
    task automatic drive(int cyc);
        int mix, pa, pc, ps, pb, ncomm, k;
        int cand[$];
        mix = (cyc / 250) % 4;
        pa = (mix == 0) ? 80 : (mix == 1) ? 5 : (mix == 2) ? 50 : 40;
        pc = (mix == 0) ? 5 : (mix == 1) ? 60 : 30;
        ps = (mix == 2) ? 8 : 0;
        pb = (mix == 3) ? 70 : 15;

        alloc_valid = ($urandom % 100) < pa;
        alloc_seq   = SW'(next_seq);

        exec_valid = 1'b0;
        foreach (q[i]) if (!q[i].execd) cand.push_back(i);
        if (cand.size() > 0 && ($urandom % 100) < 60) begin
            k = cand[$urandom % cand.size()];
            exec_valid = 1'b1;
            exec_idx   = PW'(q[k].idx);
            exec_addr  = $urandom;
            exec_size  = ZW'(1 + $urandom % 8);
            exec_data  = $urandom;
        end

        commit_valid = 1'b0;
        if (q.size() > 0 && ($urandom % 100) < pc) begin
            k = $urandom % q.size();
            commit_valid = 1'b1;
            commit_seq   = SW'(q[k].seq + 1);
        end

        squash_valid = 1'b0;
        if (($urandom % 100) < ps) begin
            ncomm = 0;
            foreach (q[i]) if (q[i].comm) ncomm++;
            k = ncomm + $urandom % (q.size() - ncomm + 1);
            squash_valid = 1'b1;
            if (k > 0)            squash_seq = SW'(q[k-1].seq);
            else if (q.size() > 0) squash_seq = SW'(q[0].seq - 1);
            else                  squash_seq = SW'(next_seq - 1);
        end

        cache_blocked = ($urandom % 100) < pb;

        wb_done = 1'b0;
        if (sent.size() > 0 && ($urandom % 100) < 50) begin
            k = $urandom % sent.size();
            wb_done     = 1'b1;
            wb_done_idx = PW'(sent[k]);
            sent.delete(k);
        end
    endtask

    // Compare every output against the reference, then advance the reference by one edge.
    task automatic compare_and_step();
        int  pend, cand, keep;
        bit  exp_wbv, full_pre, do_free;
        pend = 0;
        cand = -1;
        foreach (q[i]) begin
            if (q[i].comm && !q[i].comp) pend++;
            if (cand < 0 && !q[i].iss) cand = i;
        end
        exp_wbv  = (cand >= 0) && q[cand].comm && !cache_blocked;
        full_pre = q.size() >= E - 1;
        do_free  = q.size() > 0 && q[0].comp;

        check("R7", "count", longint'(count), q.size());
        check("R2", "full", longint'(full), full_pre);
        check("R1 R8", "tail_idx", longint'(tail_idx), tail_i);
        check("R9", "head_seq", longint'(head_seq), q.size() > 0 ? q[0].seq : 0);
        check("R4 R6", "wb_pending", longint'(wb_pending), pend);
        check("R5", "wb_valid", longint'(wb_valid), exp_wbv);
        if (exp_wbv && wb_valid) begin
            check("R5", "wb_idx", longint'(wb_idx), q[cand].idx);
            check("R3", "wb_addr", longint'(wb_addr), longint'(q[cand].addr));
            check("R3", "wb_size", longint'(wb_size), q[cand].size);
            check("R3", "wb_data", longint'(wb_data), longint'(q[cand].data));
        end

        if (exp_wbv) begin
            q[cand].iss = 1;
            sent.push_back(q[cand].idx);
        end
        if (wb_done) foreach (q[i]) if (q[i].idx == int'(wb_done_idx)) q[i].comp = 1;
        if (exec_valid) foreach (q[i]) if (q[i].idx == int'(exec_idx)) begin
            q[i].addr = exec_addr; q[i].data = exec_data;
            q[i].size = int'(exec_size); q[i].execd = 1;
        end
        if (commit_valid && !squash_valid)
            foreach (q[i]) if (q[i].seq < int'(commit_seq)) q[i].comm = 1;
        if (squash_valid) begin
            keep = 0;
            foreach (q[i]) if (q[i].seq <= int'(squash_seq)) keep++;
            while (q.size() > keep) void'(q.pop_back());
            tail_i = (head_i + keep) % E;
        end
        if (do_free) begin
            void'(q.pop_front());
            head_i = (head_i + 1) % E;
        end
        if (alloc_valid && !squash_valid && !full_pre) begin
            ment_t n;
            n = '{seq: next_seq, idx: tail_i, addr: 0, data: 0, size: 0,
                  execd: 0, comm: 0, iss: 0, comp: 0};
            q.push_back(n);
            tail_i = (tail_i + 1) % E;
            next_seq++;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state: empty buffer, nothing offered.
        check("R2", "count after reset", longint'(count), 0);
        check("R2", "full after reset", longint'(full), 0);
        check("R9", "head_seq after reset", longint'(head_seq), 0);
        check("R5", "wb_valid after reset", longint'(wb_valid), 0);
        check("R6", "wb_pending after reset", longint'(wb_pending), 0);
        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            @(negedge clk);
            drive(cyc);
            #1;
            compare_and_step();
        end
        summary();
        $finish;
    end

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

endmodule